// File: doc/BRIEF.md
# Converter Link Sequence Monitor

This block watches the 16-bit words coming out of a high-speed converter's data capture path. While the link is being brought up, the converter is told to send a known test sequence. The monitor checks that the words arrive intact, so that real capture only begins once the link shows no errors. A two-bit mode input picks the sequence to expect. The choices are a 9-stage or a 23-stage pseudo-random sequence, a constant pattern word, or that word alternating with its complement.

The monitor has no seed input. In the pseudo-random modes it predicts the next word from the last one or two received words. In the pattern modes it uses the pattern word and the phase seen in the data. After sixteen correct predictions in a row it declares lock. From then on its generator runs on its own state, and every sample is compared against it. A mismatch while locked sets a sticky flag and increments a saturating counter; a software pulse clears both. A long run of mismatches drops the lock, and the monitor hunts again.

Both pseudo-random sequences use the usual test polynomials, except that bit 15 of every word is inverted. A checker built to the plain polynomials alone would reject the data; this one accepts it.

Top module: `link_seq_monitor`

## Requirements
- R1: `mode` selects the expected sequence: 0 = 9-stage pseudo-random, 1 = 23-stage pseudo-random, 2 = constant pattern (`pat_word`), 3 = `pat_word` alternating with its bitwise complement.
- R2: In mode 0 the data is the bit stream b[n] = b[n-9] XOR b[n-5], packed 16 bits per word with the earliest bit at bit 15, and bit 15 of each word inverted. The monitor locks onto such a stream.
- R3: In mode 1 the data is the stream b[n] = b[n-23] XOR b[n-18], packed and inverted the same way. The monitor locks onto such a stream.
- R4: In mode 2 every sample is expected to equal `pat_word`. In mode 3 the samples are expected to alternate between `pat_word` and its complement, with the starting phase taken from the data.
- R5: `out_of_sync` is 1 from reset. It falls at the edge that captures the 16th consecutive correctly predicted valid sample. After a reseed, the first valid sample in modes 0 and 3, or the first two in mode 1, only seed the prediction and are not compared. No errors are counted while `out_of_sync` is 1.
- R6: While locked, the generator advances on its own state. Each valid sample that differs from the expected word sets `err_sticky` and adds one to `err_count` at the edge that captures it. A single corrupted word therefore counts exactly once.
- R7: `err_count` saturates at 0xFFFF.
- R8: The 64th consecutive mismatch while locked is still counted, and `out_of_sync` rises at that same edge. The monitor then reseeds from the incoming data. `err_sticky` and `err_count` keep their values.
- R9: An `err_clr` pulse zeroes `err_sticky` and `err_count` at the next edge, and takes precedence over an error at that same edge. It does not affect lock.
- R10: Any change of `mode` drops lock and zeroes `err_sticky` and `err_count` at the edge where the new value is first seen. The sample presented in that cycle is ignored.
- R11: Cycles with `smp_valid` low change neither lock, nor error state, nor the run of consecutive matches.
- R12: `link_clean` is 1 exactly when the monitor is locked and `err_sticky` is 0.
- R13: In modes 0 and 1, a stream that follows the plain polynomial without the bit-15 inversion never achieves lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Sequence selector (see R1) |
| pat_word | input | 16 | Expected word for the pattern modes |
| err_clr | input | 1 | Clears the sticky flag and the error counter |
| smp_valid | input | 1 | Qualifies `smp_data` in this cycle |
| smp_data | input | 16 | Reassembled converter sample |
| out_of_sync | output | 1 | 1 while the monitor has no lock |
| err_sticky | output | 1 | Set by any mismatch while locked |
| err_count | output | 16 | Saturating count of mismatches while locked |
| link_clean | output | 1 | Locked and no error seen |

## Verification
All results are registered. Lock, the sticky flag and the counter reflect a sample at the rising edge that captures it, so they are due one edge after the sample is presented, with nothing in between. The bench therefore changes inputs on falling edges and reads outputs on the next falling edge. Lock thresholds are checked at the exact sample count: one sample short stays out of sync, and the next sample locks. A loss of lock is observed right after the 64th mismatch.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    localparam int SMP_W  = 16;
    localparam int HIST_W = 2 * SMP_W;

    // tap positions into a history where bit k is the bit (k+1) steps back
    localparam int SHORT_TAP_A = 8;
    localparam int SHORT_TAP_B = 4;
    localparam int LONG_TAP_A  = 22;
    localparam int LONG_TAP_B  = 17;

    typedef logic [SMP_W-1:0]  word_t;
    typedef logic [HIST_W-1:0] hist_t;

    typedef enum logic [1:0] {
        MODE_PRBS_SHORT = 2'd0,
        MODE_PRBS_LONG  = 2'd1,
        MODE_PAT_FIXED  = 2'd2,
        MODE_PAT_TOGGLE = 2'd3
    } chk_mode_e;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } sync_st_e;

    localparam word_t TOP_BIT = word_t'(1) << (SMP_W - 1);

    function automatic logic is_prbs(input chk_mode_e m);
        return (m == MODE_PRBS_SHORT) || (m == MODE_PRBS_LONG);
    endfunction

    // remove the top-bit inversion so the history holds the plain sequence
    function automatic word_t undo_flip(input chk_mode_e m, input word_t w);
        return is_prbs(m) ? (w ^ TOP_BIT) : w;
    endfunction

    // number of received words needed before a prediction is possible
    function automatic logic [1:0] seed_words(input chk_mode_e m);
        case (m)
            MODE_PRBS_SHORT: return 2'd1;
            MODE_PRBS_LONG:  return 2'd2;
            MODE_PAT_TOGGLE: return 2'd1;
            default:         return 2'd0;
        endcase
    endfunction

    // produce the next SMP_W plain sequence bits from the history;
    // the first produced bit lands in the word's top bit
    function automatic word_t seq_advance(input hist_t h, input logic long_poly);
        hist_t w;
        word_t o;
        logic  nb;
        w = h;
        o = '0;
        for (int i = 0; i < SMP_W; i++) begin
            nb = long_poly ? (w[LONG_TAP_A] ^ w[LONG_TAP_B])
                           : (w[SHORT_TAP_A] ^ w[SHORT_TAP_B]);
            w  = {w[HIST_W-2:0], nb};
            o  = {o[SMP_W-2:0], nb};
        end
        return o;
    endfunction

endpackage

// File: rtl/lsm_expect.sv
module lsm_expect
    import lsm_pkg::*;
(
    input  chk_mode_e  mode,
    input  hist_t      hist,
    input  word_t      pat_word,
    output word_t      exp_word,
    output logic [1:0] need
);

    localparam int N_POLY = 2;

    word_t prbs_w [N_POLY];

    // one predictor per polynomial, both evaluated every cycle
    for (genvar g = 0; g < N_POLY; g++) begin : g_poly
        assign prbs_w[g] = seq_advance(hist, g == 1) ^ TOP_BIT;
    end

    always_comb begin
        case (mode)
            MODE_PRBS_SHORT: exp_word = prbs_w[0];
            MODE_PRBS_LONG:  exp_word = prbs_w[1];
            MODE_PAT_FIXED:  exp_word = pat_word;
            default:         exp_word = (hist[SMP_W-1:0] == pat_word) ? ~pat_word : pat_word;
        endcase
        need = seed_words(mode);
    end

endmodule

// File: rtl/lsm_sync.sv
module lsm_sync
    import lsm_pkg::*;
#(
    parameter int LOCK_RUN = 16,
    parameter int LOSS_RUN = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       vld,
    input  chk_mode_e  mode,
    input  word_t      data,
    input  word_t      exp_word,
    input  logic [1:0] need,
    output hist_t      hist,
    output logic       locked,
    output logic       miss_evt
);

    localparam int RUN_MAX = (LOCK_RUN > LOSS_RUN) ? LOCK_RUN : LOSS_RUN;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);

    typedef struct packed {
        sync_st_e         st;
        hist_t            hist;
        logic [1:0]       fill;
        logic [RUN_W-1:0] run;
    } sync_t;

    sync_t cur, nxt;
    logic  seeded, same;

    assign seeded   = (cur.fill >= need);
    assign same     = (data == exp_word);
    assign hist     = cur.hist;
    assign locked   = (cur.st == ST_LOCK);
    assign miss_evt = vld && !flush && (cur.st == ST_LOCK) && !same;

    always_comb begin
        nxt = cur;
        if (vld) begin
            if (cur.st == ST_HUNT) begin
                nxt.hist = {cur.hist[SMP_W-1:0], undo_flip(mode, data)};
                if (cur.fill != 2'd2) nxt.fill = cur.fill + 2'd1;
                if (seeded && same) begin
                    if (cur.run == RUN_W'(LOCK_RUN - 1)) begin
                        nxt.st  = ST_LOCK;
                        nxt.run = '0;
                    end else begin
                        nxt.run = cur.run + 1'b1;
                    end
                end else begin
                    nxt.run = '0;
                end
            end else begin
                nxt.hist = {cur.hist[SMP_W-1:0], undo_flip(mode, exp_word)};
                if (same) begin
                    nxt.run = '0;
                end else if (cur.run == RUN_W'(LOSS_RUN - 1)) begin
                    nxt.st   = ST_HUNT;
                    nxt.run  = '0;
                    nxt.fill = 2'd0;
                end else begin
                    nxt.run = cur.run + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            cur <= '{st: ST_HUNT, hist: '0, fill: 2'd0, run: '0};
        end else begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/lsm_err.sv
module lsm_err #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             clr,
    input  logic             evt,
    output logic             sticky,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || flush || clr) begin
            sticky <= 1'b0;
            count  <= '0;
        end else if (evt) begin
            sticky <= 1'b1;
            if (count != CNT_TOP) count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/link_seq_monitor.sv
module link_seq_monitor
    import lsm_pkg::*;
#(
    parameter int LOCK_RUN = 16,
    parameter int LOSS_RUN = 64,
    parameter int CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic [15:0]      pat_word,
    input  logic             err_clr,
    input  logic             smp_valid,
    input  logic [15:0]      smp_data,
    output logic             out_of_sync,
    output logic             err_sticky,
    output logic [CNT_W-1:0] err_count,
    output logic             link_clean
);

    chk_mode_e  mode_e;
    logic [1:0] mode_q;
    logic       mode_chg;
    word_t      exp_word;
    logic [1:0] need;
    hist_t      hist;
    logic       locked;
    logic       miss_evt;

    assign mode_e = chk_mode_e'(mode);

    always_ff @(posedge clk) begin
        mode_q <= mode;
    end

    assign mode_chg = !rst && (mode != mode_q);

    lsm_expect u_expect (
        .mode     (mode_e),
        .hist     (hist),
        .pat_word (pat_word),
        .exp_word (exp_word),
        .need     (need)
    );

    lsm_sync #(
        .LOCK_RUN (LOCK_RUN),
        .LOSS_RUN (LOSS_RUN)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .flush    (mode_chg),
        .vld      (smp_valid),
        .mode     (mode_e),
        .data     (smp_data),
        .exp_word (exp_word),
        .need     (need),
        .hist     (hist),
        .locked   (locked),
        .miss_evt (miss_evt)
    );

    lsm_err #(
        .CNT_W (CNT_W)
    ) u_err (
        .clk    (clk),
        .rst    (rst),
        .flush  (mode_chg),
        .clr    (err_clr),
        .evt    (miss_evt),
        .sticky (err_sticky),
        .count  (err_count)
    );

    assign out_of_sync = !locked;
    assign link_clean  = locked && !err_sticky;

endmodule

// File: rtl/lsm_checker.sv
module lsm_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode,
    input logic             err_clr,
    input logic             smp_valid,
    input logic             out_of_sync,
    input logic             err_sticky,
    input logic [CNT_W-1:0] err_count
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
        err_clr |=> (err_count == '0 && !err_sticky)); // R9

    AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (mode != $past(mode)) |=> (out_of_sync && err_count == '0 && !err_sticky)); // R10

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (err_count == CNT_TOP && !err_clr && mode == $past(mode)) |=> (err_count == CNT_TOP)); // R7

    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (err_sticky && !err_clr && mode == $past(mode)) |=> err_sticky); // R6

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!err_clr && mode == $past(mode)) |=>
            (err_count == $past(err_count) || err_count == $past(err_count) + 1'b1)); // R6

    AST_HUNT_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        out_of_sync |=> (err_count <= $past(err_count))); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && !err_clr && mode == $past(mode)) |=>
            ($stable(out_of_sync) && $stable(err_count) && $stable(err_sticky))); // R11

endmodule

bind link_seq_monitor lsm_checker #(
    .CNT_W (CNT_W)
) u_lsm_chk (
    .clk         (clk),
    .rst         (rst),
    .mode        (mode),
    .err_clr     (err_clr),
    .smp_valid   (smp_valid),
    .out_of_sync (out_of_sync),
    .err_sticky  (err_sticky),
    .err_count   (err_count)
);

// File: tb/link_seq_monitor_bench.sv
module link_seq_monitor_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  mode;
    logic [15:0] pat_word;
    logic        err_clr;
    logic        smp_valid;
    logic [15:0] smp_data;
    logic        out_of_sync;
    logic        err_sticky;
    logic [15:0] err_count;
    logic        link_clean;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [22:0] sr;

    always #5 clk = ~clk;

    link_seq_monitor u_link_seq_monitor (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode),
        .pat_word    (pat_word),
        .err_clr     (err_clr),
        .smp_valid   (smp_valid),
        .smp_data    (smp_data),
        .out_of_sync (out_of_sync),
        .err_sticky  (err_sticky),
        .err_count   (err_count),
        .link_clean  (link_clean)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            fails++;
            $display("FAIL watchdog actual=%0d cycles expected=finish earlier", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // stimulus table: mode, sample count, corrupted index (FF none),
    // plain polynomial, expected out_of_sync, expected error count, requirement
    typedef struct packed {
        logic [1:0]  m;
        logic [7:0]  n;
        logic [7:0]  bad;
        logic        plain;
        logic        oos;
        logic [15:0] cnt;
        logic [3:0]  req;
    } case_t;

    localparam int NCASE = 15;
    localparam case_t CASES [NCASE] = '{
        '{2'd0, 8'd17, 8'hFF, 1'b0, 1'b0, 16'd0, 4'd2},  // R2 locks on 17th
        '{2'd0, 8'd16, 8'hFF, 1'b0, 1'b1, 16'd0, 4'd5},  // R5 one short
        '{2'd1, 8'd18, 8'hFF, 1'b0, 1'b0, 16'd0, 4'd3},  // R3 two seed words
        '{2'd1, 8'd17, 8'hFF, 1'b0, 1'b1, 16'd0, 4'd5},  // R5 one short
        '{2'd2, 8'd16, 8'hFF, 1'b0, 1'b0, 16'd0, 4'd4},  // R4 no seed needed
        '{2'd2, 8'd15, 8'hFF, 1'b0, 1'b1, 16'd0, 4'd5},  // R5
        '{2'd3, 8'd17, 8'hFF, 1'b0, 1'b0, 16'd0, 4'd4},  // R4 alternating
        '{2'd3, 8'd16, 8'hFF, 1'b0, 1'b1, 16'd0, 4'd1},  // R1 mode 3 seed word
        '{2'd0, 8'd40, 8'd30, 1'b0, 1'b0, 16'd1, 4'd6},  // R6 one hit counted once
        '{2'd1, 8'd60, 8'd40, 1'b0, 1'b0, 16'd1, 4'd6},  // R6
        '{2'd0, 8'd60, 8'hFF, 1'b1, 1'b1, 16'd0, 4'd13}, // R13 plain short poly
        '{2'd1, 8'd60, 8'hFF, 1'b1, 1'b1, 16'd0, 4'd13}, // R13 plain long poly
        '{2'd0, 8'd40, 8'd5,  1'b0, 1'b0, 16'd0, 4'd5},  // R5 hit during hunt
        '{2'd2, 8'd30, 8'd20, 1'b0, 1'b0, 16'd1, 4'd6},  // R6 fixed pattern
        '{2'd3, 8'd30, 8'd20, 1'b0, 1'b0, 16'd1, 4'd6}   // R6 phase kept
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [15:0] d);
        smp_valid = v;
        smp_data  = d;
        @(negedge clk);
    endtask

    task automatic enter_mode(input logic [1:0] m);
        smp_valid = 1'b0;
        mode = m + 2'd1;
        @(negedge clk);
        mode = m;
        @(negedge clk);
        @(negedge clk);
    endtask

    // bit-serial reference generator, earliest bit to bit 15
    task automatic next_prbs(input logic long_poly, input logic plain, output logic [15:0] w);
        logic nb;
        for (int i = 0; i < 16; i++) begin
            nb = long_poly ? (sr[22] ^ sr[17]) : (sr[8] ^ sr[4]);
            sr = {sr[21:0], nb};
            w[15-i] = nb;
        end
        if (!plain) w[15] = ~w[15];
    endtask

    task automatic lock_fixed(input logic [15:0] p);
        enter_mode(2'd2);
        pat_word = p;
        for (int i = 0; i < 16; i++) drive(1'b1, p);
        smp_valid = 1'b0;
    endtask

    initial begin
        logic [15:0] w;
        rst = 1'b1; mode = 2'd0; pat_word = 16'hC3A5; err_clr = 1'b0;
        smp_valid = 1'b0; smp_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R5 reset out_of_sync", out_of_sync, 1);
        chk("R6 reset err_sticky", err_sticky, 0);
        chk("R6 reset err_count", err_count, 0);
        chk("R12 reset link_clean", link_clean, 0);

        for (int c = 0; c < NCASE; c++) begin
            enter_mode(CASES[c].m);
            pat_word = 16'hC3A5;
            sr = 23'h1F00D3;
            for (int i = 0; i < int'(CASES[c].n); i++) begin
                case (CASES[c].m)
                    2'd0: next_prbs(1'b0, CASES[c].plain, w);
                    2'd1: next_prbs(1'b1, CASES[c].plain, w);
                    2'd2: w = pat_word;
                    default: w = (i % 2 == 0) ? pat_word : ~pat_word;
                endcase
                if (i == int'(CASES[c].bad)) w[0] = ~w[0];
                drive(1'b1, w);
            end
            smp_valid = 1'b0;
            chk($sformatf("R%0d case %0d out_of_sync", CASES[c].req, c), out_of_sync, CASES[c].oos);
            chk($sformatf("R%0d case %0d err_count", CASES[c].req, c), err_count, CASES[c].cnt);
        end

        // R8 and R12: lock then 64 consecutive misses
        enter_mode(2'd0);
        sr = 23'h1F00D3;
        for (int i = 0; i < 17; i++) begin
            next_prbs(1'b0, 1'b0, w);
            drive(1'b1, w);
        end
        chk("R12 locked and clean", link_clean, 1);
        for (int i = 0; i < 63; i++) drive(1'b1, 16'h0000);
        chk("R8 still locked after 63 misses", out_of_sync, 0);
        chk("R8 count after 63 misses", err_count, 63);
        drive(1'b1, 16'h0000);
        chk("R8 lock lost at 64th miss", out_of_sync, 1);
        chk("R8 64th miss counted", err_count, 64);
        chk("R12 not clean after loss", link_clean, 0);
        for (int i = 0; i < 5; i++) drive(1'b1, 16'h0000);
        chk("R8 sticky kept while hunting", err_sticky, 1);
        chk("R8 no count while hunting", err_count, 64);

        // R9: clear pulse and its precedence
        lock_fixed(16'h1234);
        for (int i = 0; i < 3; i++) drive(1'b1, 16'h0000);
        chk("R9 pre-clear count", err_count, 3);
        err_clr = 1'b1;
        drive(1'b0, 16'h0000);
        err_clr = 1'b0;
        chk("R9 clear count", err_count, 0);
        chk("R9 clear sticky", err_sticky, 0);
        chk("R9 lock kept on clear", out_of_sync, 0);
        err_clr = 1'b1;
        drive(1'b1, 16'h0000);
        err_clr = 1'b0;
        chk("R9 clear beats error", err_count, 0);
        drive(1'b1, 16'h0000);
        chk("R9 counting resumes", err_count, 1);

        // R11: invalid cycles leave state alone
        for (int i = 0; i < 5; i++) drive(1'b0, 16'hDEAD);
        chk("R11 count unchanged when idle", err_count, 1);
        chk("R11 lock unchanged when idle", out_of_sync, 0);

        // R10: mode change with a bad sample in the same cycle
        mode = 2'd3;
        drive(1'b1, 16'h0000);
        smp_valid = 1'b0;
        chk("R10 lock dropped", out_of_sync, 1);
        chk("R10 count zeroed", err_count, 0);
        chk("R10 sticky zeroed", err_sticky, 0);

        // R11: gaps do not break the run of matches
        enter_mode(2'd2);
        pat_word = 16'h0F0F;
        for (int i = 0; i < 10; i++) drive(1'b1, 16'h0F0F);
        for (int i = 0; i < 5; i++) drive(1'b0, 16'hBEEF);
        for (int i = 0; i < 5; i++) drive(1'b1, 16'h0F0F);
        chk("R11 15 matches across gap", out_of_sync, 1);
        drive(1'b1, 16'h0F0F);
        smp_valid = 1'b0;
        chk("R11 16th match across gap locks", out_of_sync, 0);

        // R7: drive the counter into saturation
        lock_fixed(16'h1234);
        for (int k = 0; k < 1041; k++) begin
            for (int i = 0; i < 63; i++) drive(1'b1, 16'h0000);
            drive(1'b1, 16'h1234);
        end
        smp_valid = 1'b0;
        chk("R7 counter saturated", err_count, 16'hFFFF);
        chk("R7 still locked", out_of_sync, 0);
        chk("R6 sticky set", err_sticky, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule